// File: doc/BRIEF.md
# Scan Chain with Parked Functional Outputs

This block is a serial test chain of `N` storage cells that keeps test power down while patterns shift through it. Each cell holds one bit and drives two outputs. The functional output feeds the combinational logic under test. The scan output feeds the serial input of the next cell. While shifting, every functional output is held at a constant fixed for that cell at elaboration time. The logic it drives therefore sits still in one chosen input state, which can be picked as a low-leakage vector, while the bits move along the chain underneath.

Each cell works in one of two modes, and `scan_en` picks the mode. In **MODE_CAPTURE** (`scan_en` low), the cell loads its functional data bit on every rising clock edge, and its functional output shows the stored bit. In **MODE_SHIFT** (`scan_en` high), the cell loads from the previous cell on every edge, and its functional output shows its park bit. A rise of `scan_en` is the transition from capture to shift. A fall of `scan_en` is the transition from shift to capture. No clock edge is involved in either transition.

One test pattern is `N` clocks in shift mode followed by one clock in capture mode. `P` patterns therefore take `N*P` shift clocks plus `P` capture clocks. The park vector is the parameter `PARK_VALUE`. Bit `i` of it belongs to cell `i`, and cell 0 is the cell nearest `scan_in`.

Top module: `parked_scan_chain`

## Requirements
- R1: While `rst` is high at a rising clock edge, every cell's stored bit becomes 0. After reset, `func_q` reads all zeros when `scan_en` is low and reads `PARK_VALUE` when `scan_en` is high. `scan_out` reads 0.
- R2: With `scan_en` low, `func_q[i]` equals the bit stored in cell `i`. This holds for park-high and park-low cells alike.
- R3: On a rising edge with `scan_en` low and `rst` low, cell `i` stores `func_d[i]`.
- R4: On a rising edge with `scan_en` high and `rst` low, cell 0 stores `scan_in` and cell `i+1` stores the previous bit of cell `i`. `scan_out` is the bit of cell `N-1`.
- R5: While `scan_en` is high, `func_q[i]` equals `PARK_VALUE[i]` (1 for a park-high cell, 0 for a park-low cell), whatever the cell holds.
- R6: While `scan_en` stays high across a rising edge, `func_q` does not change at that edge.
- R7: Each cell's scan output follows its stored bit in both modes. In particular, `scan_out` shows `func_d[N-1]` right after a capture edge.
- R8: `N` shift clocks unload the previous contents on `scan_out`, cell `N-1` first and cell 0 last, while loading a new pattern. Driving bit `N-1-k` of a pattern on `scan_in` at shift step `k` leaves bit `j` of that pattern in cell `j`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | 1 selects shift mode, 0 selects capture mode |
| scan_in | input | 1 | Serial input to cell 0 |
| func_d | input | N | Functional data bits, bit i to cell i |
| func_q | output | N | Functional outputs, parked during shift |
| scan_out | output | 1 | Serial output, the bit of cell N-1 |

## Verification
The bench watches `func_q` at every step of a full `N`-clock shift. A design that let the stored bit leak through during shifting would toggle the downstream inputs, and this catches it. A park vector with mixed ones and zeros exposes a swapped or mis-indexed constant. The unloaded stream is checked bit by bit against the pattern captured before. A chain with reversed order or an extra pipeline stage would show the wrong bit or a one-clock slip. Capture checks follow shift directly, and the last check drops `scan_en` with no clock edge. A design that parked outputs after shift had ended, or that failed to capture, would present stale data.

// File: rtl/parked_scan_pkg.sv
package parked_scan_pkg;

    typedef enum logic {
        MODE_CAPTURE = 1'b0,
        MODE_SHIFT   = 1'b1
    } cell_mode_e;

endpackage

// File: rtl/parked_scan_cell.sv
module parked_scan_cell
    import parked_scan_pkg::*;
#(
    parameter logic PARK_BIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic scan_en,
    input  logic scan_in,
    input  logic func_d,
    output logic func_q,
    output logic scan_q
);

    cell_mode_e mode;
    logic       state_q;

    assign mode   = scan_en ? MODE_SHIFT : MODE_CAPTURE;
    assign scan_q = state_q;

    // state register: capture or shift depending on mode
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= 1'b0;
        end else begin
            unique case (mode)
                MODE_CAPTURE: state_q <= func_d;
                MODE_SHIFT:   state_q <= scan_in;
                default:      state_q <= state_q;
            endcase
        end
    end

    // output process: park the functional output during shift
    always_comb begin
        unique case (mode)
            MODE_CAPTURE: func_q = state_q;
            MODE_SHIFT:   func_q = PARK_BIT;
            default:      func_q = state_q;
        endcase
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (scan_q == 1'b0));

    // R3
    capture_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && !scan_en) |=> (scan_q == $past(func_d)));

    // R4
    shift_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && scan_en) |=> (scan_q == $past(scan_in)));

    // R6
    park_hold_chk: assert property (@(posedge clk) disable iff (rst)
        scan_en |=> (!scan_en || $stable(func_q)));

    // R2
    normal_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !scan_en |-> (func_q == scan_q));

endmodule

// File: rtl/parked_scan_chain.sv
module parked_scan_chain
    import parked_scan_pkg::*;
#(
    parameter int           N          = 8,
    parameter logic [N-1:0] PARK_VALUE = 8'hA5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         scan_en,
    input  logic         scan_in,
    input  logic [N-1:0] func_d,
    output logic [N-1:0] func_q,
    output logic         scan_out
);

    localparam int LINKS = N + 1;

    logic [LINKS-1:0] link;

    assign link[0]  = scan_in;
    assign scan_out = link[N];

    for (genvar i = 0; i < N; i++) begin : g_cell
        parked_scan_cell #(
            .PARK_BIT (PARK_VALUE[i])
        ) u_cell (
            .clk     (clk),
            .rst     (rst),
            .scan_en (scan_en),
            .scan_in (link[i]),
            .func_d  (func_d[i]),
            .func_q  (func_q[i]),
            .scan_q  (link[i+1])
        );
    end

    // R4
    chain_tail_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && scan_en) |=> (scan_out == $past(link[N-1])));

    // R5
    park_vector_chk: assert property (@(posedge clk) disable iff (rst)
        scan_en |-> (func_q == PARK_VALUE));

endmodule

// File: tb/parked_scan_chain_bench.sv
module parked_scan_chain_bench;

    localparam int           N    = 8;
    localparam logic [N-1:0] PARK = 8'hA5;

    logic         clk = 1'b0;
    logic         rst;
    logic         scan_en;
    logic         scan_in;
    logic [N-1:0] func_d;
    logic [N-1:0] func_q;
    logic         scan_out;

    int applied = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    parked_scan_chain #(.N(N), .PARK_VALUE(PARK)) u_parked_scan_chain (
        .clk      (clk),
        .rst      (rst),
        .scan_en  (scan_en),
        .scan_in  (scan_in),
        .func_d   (func_d),
        .func_q   (func_q),
        .scan_out (scan_out)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        applied++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one rising edge, back at a falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; scan_en = 1'b0; scan_in = 1'b0; func_d = '1;
        step(); step();
        chk("R1 func_q after reset", func_q, '0);
        chk("R1 scan_out after reset", {{(N-1){1'b0}}, scan_out}, '0);
        scan_en = 1'b1;
        #1 chk("R1 parked after reset", func_q, PARK);
        rst = 1'b0; scan_en = 1'b0;
    endtask

    task automatic t_capture(input logic [N-1:0] val);
        scan_en = 1'b0; func_d = val;
        step();
        chk("R3 capture", func_q, val);
        chk("R7 scan_out after capture", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, val[N-1]});
        func_d = ~val;
        #1 chk("R2 func_q follows state", func_q, val);
    endtask

    task automatic t_shift(input logic [N-1:0] newpat, input logic [N-1:0] oldpat);
        scan_en = 1'b1;
        func_d  = $urandom;
        for (int k = 0; k < N; k++) begin
            scan_in = newpat[N-1-k];
            #1;
            chk("R8 unload order", {{(N-1){1'b0}}, scan_out}, {{(N-1){1'b0}}, oldpat[N-1-k]});
            chk("R5 parked", func_q, PARK);
            step();
            chk("R6 no change during shift", func_q, PARK);
        end
        scan_en = 1'b0;
        #1 chk("R4 shifted contents", func_q, newpat);
    endtask

    initial begin
        logic [N-1:0] a, b, c;
        rst = 1'b1; scan_en = 1'b0; scan_in = 1'b0; func_d = '0;
        t_reset();
        t_capture(8'h3C);
        a = $urandom;
        t_shift(a, 8'h3C);
        b = $urandom;
        t_capture(b);
        c = $urandom;
        t_shift(c, b);
        t_shift(8'hFF, c);
        t_capture('0);
        t_shift(8'h5A, '0);
        t_capture('1);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", applied, misses);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            applied++;
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", applied, misses);
            $finish;
        end
    end

endmodule